// File: doc/BRIEF.md
# Handler binning output sequencer

This block drives four digital lines toward a component handler after each limit test. A start-of-test strobe arrives from the handler with a selectable active polarity. The block passes it through a two-flop synchronizer and an edge detector, and that edge arms a sequence. When the limit logic reports a result, the block places the pass or the fail pattern on lines 1 to 3. Line 4 then serves as the end-of-test strobe. It asserts one timebase tick after lines 1 to 3 change, and lines 1 to 3 return to their clear levels one tick after line 4 releases. All timing counts pulses of a 10 µs timebase enable.

With auto-clear on, line 4 stays asserted for a programmed number of ticks (up to 2^23 - 1, enough for 60 s). The outputs then fall back to the clear pattern without further action. With auto-clear off, line 4 stays asserted until a clear command arrives. The clear level of line 4 comes from the busy mode, not from the clear pattern. The configuration inputs are plain register-style levels. They are captured when a sequence starts.

Top module: `handler_bin_seq`

## Requirements
- R1: While `rst` is high, `dout` is 0 and `seq_done` is 0. In idle, `dout[2:0]` follows `clear_pat[2:0]` and `dout[3]` shows the line-4 clear level (`dout[0]` is line 1).
- R2: A sequence starts only on an edge of `sot_in` toward its active level while idle. `sot_hi`=1 selects a rising edge and 0 selects a falling edge. A start edge outside idle has no effect.
- R3: On `test_done` while a test is running, `dout[2:0]` takes `pass_pat[2:0]` when `test_pass`=1 and `fail_pat[2:0]` otherwise. It keeps that value until the sequence ends.
- R4: With `busy_inv`=0 the clear level of line 4 is low and its asserted level is high. With `busy_inv`=1 the clear level is high and the asserted level is low. `clear_pat[3]`, `pass_pat[3]` and `fail_pat[3]` are unused.
- R5: After the result, line 4 stays at its clear level until the next `tick` (lead phase of one to one tick period).
- R6: With `auto_clear`=1 and delay D>0, line 4 is asserted for exactly D tick periods. Lines 1 to 3 then hold the result for exactly one further tick period.
- R7: With `auto_clear`=1 and D=0, line 4 never asserts, and lines 1 to 3 show the result for the lead plus one tick period.
- R8: With `auto_clear`=0, line 4 stays asserted until `clear_cmd`. The trail phase then ends at the next `tick`.
- R9: `seq_done` pulses for one cycle, in the same cycle in which `dout` returns to the clear pattern.
- R10: The delay, patterns, busy mode and auto-clear setting are captured at the start edge. Changes made during a sequence do not affect it.
- R11: `test_done` outside a running test is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 10 µs timebase enable |
| sot_in | input | 1 | Asynchronous start-of-test line from handler |
| sot_hi | input | 1 | 1: high-going start pulse, 0: low-going |
| test_done | input | 1 | Limit test finished (one cycle) |
| test_pass | input | 1 | Result qualifier with test_done |
| pass_pat | input | 4 | Pass output pattern |
| fail_pat | input | 4 | Fail output pattern |
| clear_pat | input | 4 | No-action pattern |
| auto_clear | input | 1 | Enable timed return to clear |
| delay_ticks | input | DW | Line-4 pulse width in ticks |
| busy_inv | input | 1 | Line-4 mode: 0 busy (clear low), 1 inverted busy (clear high) |
| clear_cmd | input | 1 | Clear request when auto-clear is off |
| dout | output | 4 | Handler lines 1..4 (bit 0 = line 1) |
| seq_done | output | 1 | Return-to-clear pulse |

## Verification
A start edge needs four clock edges to cross the synchronizer, the edge register and the state register. The bench waits six cycles before it gives the result. The result pattern appears at the first clock edge after `test_done`. Every later phase boundary sits on a `tick` edge. The bench generates ticks at a fixed period and samples every falling edge, so it can count each phase in cycles. It expects a strobe of exactly D periods and a trail of exactly one period, and it bounds the lead to between one cycle and one period.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TESTING,
    ST_LEAD,
    ST_STROBE,
    ST_TRAIL,
    ST_HOLD
  } hbs_state_e;
endpackage

// File: rtl/hbs_sot_detect.sv
module hbs_sot_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sot_in,
  input  logic sot_hi,
  output logic sot_evt
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  // synchronizer chain plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      sot_evt <= 1'b0;
    end else begin
      sh_q    <= {sh_q[LAST-1:0], sot_in};
      // edge on the raw level, so a polarity change alone is not an edge
      sot_evt <= sot_hi ? (sh_q[LAST-1] & ~sh_q[LAST])
                        : (~sh_q[LAST-1] & sh_q[LAST]);
    end
  end
endmodule

// File: rtl/hbs_tick_counter.sv
module hbs_tick_counter #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (dec && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/handler_bin_seq.sv
module handler_bin_seq
  import hbs_pkg::*;
#(
  parameter int DW       = 23,
  parameter int NLINES   = 4,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              sot_in,
  input  logic              sot_hi,
  input  logic              test_done,
  input  logic              test_pass,
  input  logic [NLINES-1:0] pass_pat,
  input  logic [NLINES-1:0] fail_pat,
  input  logic [NLINES-1:0] clear_pat,
  input  logic              auto_clear,
  input  logic [DW-1:0]     delay_ticks,
  input  logic              busy_inv,
  input  logic              clear_cmd,
  output logic [NLINES-1:0] dout,
  output logic              seq_done
);
  localparam int DL = NLINES - 1;  // data lines below the strobe line

  hbs_state_e state_q, state_n;

  logic            sot_evt;
  logic            cnt_last;
  logic            cap_cfg, cap_res, ld_cnt, fin;
  logic [DW-1:0]   dly_q;
  logic            auto_q, binv_q;
  logic [DL-1:0]   clr_q, pass_q, fail_q, res_q;
  logic [DL-1:0]   clr_eff, res_eff;
  logic            binv_eff;
  logic [NLINES-1:0] dout_d;

  hbs_sot_detect #(.STAGES(SYNC_STG)) u_sot (
    .clk(clk), .rst(rst), .sot_in(sot_in), .sot_hi(sot_hi), .sot_evt(sot_evt)
  );

  hbs_tick_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst(rst), .load(ld_cnt), .load_val(dly_q),
    .dec(tick && state_q == ST_STROBE), .last(cnt_last)
  );

  always_comb begin
    state_n = state_q;
    cap_cfg = 1'b0;
    cap_res = 1'b0;
    ld_cnt  = 1'b0;
    fin     = 1'b0;
    case (state_q)
      ST_IDLE:    if (sot_evt) begin cap_cfg = 1'b1; state_n = ST_TESTING; end
      ST_TESTING: if (test_done) begin cap_res = 1'b1; state_n = ST_LEAD; end
      ST_LEAD:
        if (tick) begin
          if (!auto_q)            state_n = ST_HOLD;
          else if (dly_q == '0)   state_n = ST_TRAIL;
          else begin              state_n = ST_STROBE; ld_cnt = 1'b1; end
        end
      ST_STROBE:  if (tick && cnt_last) state_n = ST_TRAIL;
      ST_HOLD:    if (clear_cmd) state_n = ST_TRAIL;
      ST_TRAIL:   if (tick) begin state_n = ST_IDLE; fin = 1'b1; end
      default:    state_n = ST_IDLE;
    endcase
  end

  // values valid in the cycle they are captured
  assign clr_eff  = cap_cfg ? clear_pat[DL-1:0] : clr_q;
  assign binv_eff = cap_cfg ? busy_inv : binv_q;
  assign res_eff  = cap_res ? (test_pass ? pass_q : fail_q) : res_q;

  always_comb begin
    case (state_n)
      ST_IDLE:             dout_d = {busy_inv, clear_pat[DL-1:0]};
      ST_TESTING:          dout_d = {binv_eff, clr_eff};
      ST_LEAD, ST_TRAIL:   dout_d = {binv_eff, res_eff};
      ST_STROBE, ST_HOLD:  dout_d = {~binv_eff, res_eff};
      default:             dout_d = {busy_inv, clear_pat[DL-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      dly_q    <= '0;
      auto_q   <= 1'b0;
      binv_q   <= 1'b0;
      clr_q    <= '0;
      pass_q   <= '0;
      fail_q   <= '0;
      res_q    <= '0;
      dout     <= '0;
      seq_done <= 1'b0;
    end else begin
      state_q  <= state_n;
      dout     <= dout_d;
      seq_done <= fin;
      if (cap_cfg) begin
        dly_q  <= delay_ticks;
        auto_q <= auto_clear;
        binv_q <= busy_inv;
        clr_q  <= clear_pat[DL-1:0];
        pass_q <= pass_pat[DL-1:0];
        fail_q <= fail_pat[DL-1:0];
      end
      if (cap_res)
        res_q <= res_eff;
    end
  end
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker
  import hbs_pkg::*;
#(
  parameter int DW = 23
) (
  input logic          clk,
  input logic          rst,
  input hbs_state_e    state,
  input logic [DW-1:0] dly_q,
  input logic          auto_q,
  input logic          seq_done
);
  // R2
  testing_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TESTING && $past(state) != ST_TESTING) |-> $past(state) == ST_IDLE);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(dly_q));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

  // R9
  done_from_trail_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> ($past(state) == ST_TRAIL && state == ST_IDLE));

  // R8
  hold_manual_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_HOLD |-> !auto_q);

  // R5
  strobe_after_lead_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STROBE && $past(state) != ST_STROBE) |-> $past(state) == ST_LEAD);
endmodule

bind handler_bin_seq hbs_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .state(state_q), .dly_q(dly_q),
  .auto_q(auto_q), .seq_done(seq_done)
);

// File: tb/handler_bin_seq_test.sv
module handler_bin_seq_test;
  localparam int CLK_P = 10;
  localparam int TP    = 4;
  localparam int DW    = 23;

  logic clk, rst, tick, sot_in, sot_hi, test_done, test_pass;
  logic [3:0] pass_pat, fail_pat, clear_pat, dout;
  logic auto_clear, busy_inv, clear_cmd, seq_done;
  logic [DW-1:0] delay_ticks;

  int n_vec = 0;
  int n_bad = 0;
  int tdiv;
  int wd = 0;
  bit over = 0;

  handler_bin_seq #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .sot_in(sot_in), .sot_hi(sot_hi),
    .test_done(test_done), .test_pass(test_pass), .pass_pat(pass_pat),
    .fail_pat(fail_pat), .clear_pat(clear_pat), .auto_clear(auto_clear),
    .delay_ticks(delay_ticks), .busy_inv(busy_inv), .clear_cmd(clear_cmd),
    .dout(dout), .seq_done(seq_done)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin
      tdiv <= 0;
      tick <= 1'b0;
    end else begin
      tdiv <= (tdiv == TP-1) ? 0 : tdiv + 1;
      tick <= (tdiv == TP-1);
    end
  end

  always @(posedge clk) begin
    wd = wd + 1;
    if (wd > 150000 && !over) begin
      over = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input bit pol, input bit binv, input bit au, input bit ps,
                         input int d, input logic [3:0] clr,
                         input logic [3:0] pp, input logic [3:0] fp);
    logic [3:0] res;
    int lead, strb, trl;
    bit seen, patok, got, quiet;
    lead = 0; strb = 0; trl = 0; seen = 0; patok = 1; got = 0; quiet = 1;
    @(negedge clk);
    sot_hi = pol; sot_in = ~pol; busy_inv = binv; auto_clear = au;
    delay_ticks = DW'(d); clear_pat = clr; pass_pat = pp; fail_pat = fp;
    repeat (6) @(negedge clk);
    // R1 R4: idle level
    chk(dout == {binv, clr[2:0]}, "R1 R4 idle", dout, {binv, clr[2:0]});
    sot_in = pol; repeat (2) @(negedge clk); sot_in = ~pol;
    repeat (6) @(negedge clk);
    // R10: change delay after start; R2: second start edge ignored
    delay_ticks = DW'(d + 3);
    sot_in = pol; repeat (2) @(negedge clk); sot_in = ~pol;
    repeat (6) @(negedge clk);
    chk(dout == {binv, clr[2:0]}, "R2 testing clear", dout, {binv, clr[2:0]});
    test_pass = ps; test_done = 1'b1;
    @(negedge clk);
    test_done = 1'b0;
    res = ps ? pp : fp;
    for (int i = 0; i < 2000 && !got; i++) begin
      if (seq_done) got = 1;
      else begin
        if (dout[2:0] != res[2:0]) patok = 0;
        if (dout[3] == ~binv) begin
          seen = 1; strb++;
          if (!au && strb == 2*TP) clear_cmd = 1'b1;
        end else if (!seen) lead++;
        else trl++;
        @(negedge clk);
        clear_cmd = 1'b0;
      end
    end
    chk(got, "R9 done seen", got, 1);
    chk(patok, "R3 result lines", patok, 1);
    chk(dout == {binv, clr[2:0]}, "R9 clear at done", dout, {binv, clr[2:0]});
    if (au && d > 0) begin
      chk(strb == d*TP, "R6 R10 strobe width", strb, d*TP);
      chk(lead >= 1 && lead <= TP, "R5 lead", lead, TP);
      chk(trl == TP, "R6 trail", trl, TP);
    end else if (au) begin
      chk(strb == 0, "R7 no strobe", strb, 0);
      chk(lead >= TP+1 && lead <= 2*TP, "R7 window", lead, 2*TP);
    end else begin
      chk(strb == 2*TP, "R8 held strobe", strb, 2*TP);
      chk(lead >= 1 && lead <= TP, "R5 lead", lead, TP);
      chk(trl >= 1 && trl <= TP, "R8 trail", trl, TP);
    end
    @(negedge clk);
    chk(!seq_done, "R9 single pulse", seq_done, 0);
    // R11: done while idle
    test_done = 1'b1; @(negedge clk); test_done = 1'b0;
    for (int i = 0; i < 3*TP; i++) begin
      if (dout != {binv, clr[2:0]} || seq_done) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, "R11 stray done", quiet, 1);
  endtask

  initial begin
    int idx;
    rst = 1'b1; sot_in = 1'b0; sot_hi = 1'b1; test_done = 1'b0; test_pass = 1'b0;
    pass_pat = '0; fail_pat = '0; clear_pat = 4'hF; auto_clear = 1'b1;
    delay_ticks = '0; busy_inv = 1'b1; clear_cmd = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dout == 4'h0 && !seq_done, "R1 reset", dout, 0);
    rst = 1'b0;
    idx = 0;
    for (int pol = 0; pol < 2; pol++)
      for (int bi = 0; bi < 2; bi++)
        for (int au = 0; au < 2; au++)
          for (int ps = 0; ps < 2; ps++)
            for (int di = 0; di < 3; di++) begin
              logic [3:0] c, p, f;
              c = (idx == 0) ? 4'hF : 4'(idx * 5);
              p = 4'(idx * 3 + 6);
              f = (idx == 0) ? 4'b0001 : 4'(~idx);
              run_seq(pol[0], bi[0], au[0], ps[0], (di == 2) ? 3 : di, c, p, f);
              idx++;
            end
    over = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule